// File: doc/BRIEF.md
# Extended Mantissa Adder With Carry Renormalization

This block adds two unsigned extended mantissas. Each operand is a 64-bit mantissa with an 8-bit guard byte below it, and the block treats the pair as one 72-bit carry chain. The guard bytes are summed first. Their carry ripples into the low mantissa word and then into the high word. The carry out of the high word decides whether the result needs renormalization.

When there is no carry, the sum passes through as it is. When there is a carry, the block moves the result down one place and raises the exponent by one. The bit that falls off the mantissa goes into the guard byte, together with a sticky bit that records the old guard contents. If the raised exponent reaches its all-ones value, the result saturates to a zero mantissa and the block raises the overflow and inexact flags.

A caller pulses a start strobe with the operands and the common exponent. The registered result comes back one clock later with a one-cycle done strobe. Signs, exponent alignment and subtraction are handled elsewhere.

Top module: `mant_add_renorm`

## Requirements
- R1: The result is registered. `done_o` is high for exactly the one cycle after each cycle in which `start_i` is high. Between starts, all result outputs hold their last value.
- R2: With no carry out of bit 71 of the 72-bit sum {mantissa, guard}, `mant_o` and `guard_o` equal the low 72 bits of the sum, `exp_o` equals `exp_i`, and both flags are 0.
- R3: The guard byte sum carries into mantissa bit 0, and carries pass from the low 32-bit word into the high 32-bit word.
- R4: With a carry and an incremented exponent below all-ones, `exp_o` = `exp_i`+1 and `mant_o` = {1, sum mantissa bits 63..1}.
- R5: In the R4 case, `guard_o` bit 7 is sum mantissa bit 0, bits 6..1 are 0, and bit 0 is 1 exactly when the summed guard byte is nonzero.
- R6: With a carry and `exp_i`+1 equal to 0x7FFF, the result is as follows: `ovf_o` is 1, `mant_o` is 0, `exp_o` is 0x7FFF, and `guard_o` keeps the summed guard byte.
- R7: In the R6 case, `inx_o` is 1 exactly when the 64-bit sum mantissa was nonzero. In every other case, `inx_o` is 0.
- R8: Flags are evaluated afresh on each start. A no-carry operation after an overflow returns both flags to 0.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe |
| a_mant_i | input | 64 | Operand A mantissa |
| a_guard_i | input | 8 | Operand A guard byte |
| b_mant_i | input | 64 | Operand B mantissa |
| b_guard_i | input | 8 | Operand B guard byte |
| exp_i | input | 15 | Common exponent of both operands |
| mant_o | output | 64 | Result mantissa |
| guard_o | output | 8 | Result guard byte |
| exp_o | output | 15 | Result exponent |
| ovf_o | output | 1 | Exponent overflow |
| inx_o | output | 1 | Nonzero mantissa lost at overflow |
| done_o | output | 1 | Result valid strobe |

## Verification
The block has only one stage of state, so any wrong internal value appears at the outputs in the cycle after the start that produced it.
- A broken carry link between the guard byte and the mantissa words shows up as a mantissa one unit off at a word boundary.
- A lost sticky bit, or a misplaced shifted-out bit, shows up in `guard_o` on renormalizing operations.
- A bad overflow compare shows up as a nonzero mantissa, or a wrong flag, at exponent 0x7FFE.
- Because every output is compared against a reference on every clock, a register that fails to hold between starts shows up in the very next idle cycle.

// File: rtl/mant_add_pkg.sv
package mant_add_pkg;
  parameter int MANT_W  = 64;
  parameter int GUARD_W = 8;
  parameter int WORD_W  = 32;
  parameter int EXP_W   = 15;

  typedef struct packed {
    logic [MANT_W-1:0]  mant;
    logic [GUARD_W-1:0] guard;
    logic [EXP_W-1:0]   exp;
    logic               ovf;
    logic               inx;
  } ext_res_t;
endpackage

// File: rtl/mant_seg_add.sv
module mant_seg_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] tot;
  assign tot = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};
  assign s_o = tot[W-1:0];
  assign c_o = tot[W];
endmodule

// File: rtl/mant_carry_chain.sv
module mant_carry_chain #(
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int WORD_W  = 32
) (
  input  logic [MANT_W-1:0]  a_mant_i,
  input  logic [GUARD_W-1:0] a_guard_i,
  input  logic [MANT_W-1:0]  b_mant_i,
  input  logic [GUARD_W-1:0] b_guard_i,
  output logic [MANT_W-1:0]  sum_mant_o,
  output logic [GUARD_W-1:0] sum_guard_o,
  output logic               carry_o
);
  localparam int N_WORDS = MANT_W / WORD_W;

  logic [N_WORDS:0] cy;

  // guard byte is the lowest link of the chain
  mant_seg_add #(.W(GUARD_W)) u_guard (
    .a_i(a_guard_i), .b_i(b_guard_i), .c_i(1'b0),
    .s_o(sum_guard_o), .c_o(cy[0])
  );

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    mant_seg_add #(.W(WORD_W)) u_word (
      .a_i(a_mant_i[g*WORD_W +: WORD_W]),
      .b_i(b_mant_i[g*WORD_W +: WORD_W]),
      .c_i(cy[g]),
      .s_o(sum_mant_o[g*WORD_W +: WORD_W]),
      .c_o(cy[g+1])
    );
  end

  assign carry_o = cy[N_WORDS];
endmodule

// File: rtl/mant_renorm.sv
module mant_renorm
  import mant_add_pkg::*;
(
  input  logic [MANT_W-1:0]  sum_mant_i,
  input  logic [GUARD_W-1:0] sum_guard_i,
  input  logic               carry_i,
  input  logic [EXP_W-1:0]   exp_i,
  output ext_res_t           res_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [EXP_W-1:0] EXP_ONE = {{(EXP_W-1){1'b0}}, 1'b1};

  logic [EXP_W-1:0] exp_inc;
  assign exp_inc = exp_i + EXP_ONE;

  always_comb begin
    res_o.mant  = sum_mant_i;
    res_o.guard = sum_guard_i;
    res_o.exp   = exp_i;
    res_o.ovf   = 1'b0;
    res_o.inx   = 1'b0;
    if (carry_i) begin
      if (exp_inc == EXP_MAX) begin
        res_o.mant = '0;
        res_o.exp  = EXP_MAX;
        res_o.ovf  = 1'b1;
        res_o.inx  = |sum_mant_i;
      end else begin
        res_o.mant  = {1'b1, sum_mant_i[MANT_W-1:1]};
        res_o.guard = {sum_mant_i[0], {(GUARD_W-2){1'b0}}, |sum_guard_i};
        res_o.exp   = exp_inc;
      end
    end
  end
endmodule

// File: rtl/mant_add_renorm.sv
module mant_add_renorm
  import mant_add_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [MANT_W-1:0]  a_mant_i,
  input  logic [GUARD_W-1:0] a_guard_i,
  input  logic [MANT_W-1:0]  b_mant_i,
  input  logic [GUARD_W-1:0] b_guard_i,
  input  logic [EXP_W-1:0]   exp_i,
  output logic [MANT_W-1:0]  mant_o,
  output logic [GUARD_W-1:0] guard_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic               ovf_o,
  output logic               inx_o,
  output logic               done_o
);
  logic [MANT_W-1:0]  sum_mant;
  logic [GUARD_W-1:0] sum_guard;
  logic               carry;
  ext_res_t           nxt, res_q;
  logic               done_q;

  mant_carry_chain #(.MANT_W(MANT_W), .GUARD_W(GUARD_W), .WORD_W(WORD_W)) u_chain (
    .a_mant_i(a_mant_i), .a_guard_i(a_guard_i),
    .b_mant_i(b_mant_i), .b_guard_i(b_guard_i),
    .sum_mant_o(sum_mant), .sum_guard_o(sum_guard), .carry_o(carry)
  );

  mant_renorm u_renorm (
    .sum_mant_i(sum_mant), .sum_guard_i(sum_guard), .carry_i(carry),
    .exp_i(exp_i), .res_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) res_q <= nxt;
    end
  end

  assign mant_o  = res_q.mant;
  assign guard_o = res_q.guard;
  assign exp_o   = res_q.exp;
  assign ovf_o   = res_q.ovf;
  assign inx_o   = res_q.inx;
  assign done_o  = done_q;

  assert_done_follows_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_done_needs_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  assert_hold_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(mant_o) && $stable(exp_o) && $stable(guard_o)));
  assert_renorm_top_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ovf_o && exp_o != $past(exp_i)) |-> mant_o[MANT_W-1]);
  assert_ovf_saturates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (mant_o == '0 && exp_o == '1));
  assert_inx_needs_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inx_o |-> ovf_o);
endmodule

// File: tb/tb_mant_add_renorm.sv
module tb_mant_add_renorm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] a_m = '0, b_m = '0;
  logic [7:0]  a_g = '0, b_g = '0;
  logic [14:0] e_in = '0;
  logic [63:0] mant;
  logic [7:0]  guard;
  logic [14:0] exp_r;
  logic        ovf, inx, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string cur_tag = "R2";

  // reference model state
  logic [63:0] m_mant;
  logic [7:0]  m_guard;
  logic [14:0] m_exp;
  logic        m_ovf, m_inx, m_done;
  string       m_tag = "R9";

  always #10 clk = ~clk;

  mant_add_renorm dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_mant_i(a_m), .a_guard_i(a_g), .b_mant_i(b_m), .b_guard_i(b_g),
    .exp_i(e_in), .mant_o(mant), .guard_o(guard), .exp_o(exp_r),
    .ovf_o(ovf), .inx_o(inx), .done_o(done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mant <= '0; m_guard <= '0; m_exp <= '0;
      m_ovf <= 0; m_inx <= 0; m_done <= 0; m_tag <= "R9";
    end else begin
      m_done <= start;
      m_tag  <= start ? cur_tag : "R1";
      if (start) begin
        logic [72:0] s;
        logic [14:0] e1;
        s  = {1'b0, a_m, a_g} + {1'b0, b_m, b_g};
        e1 = e_in + 15'd1;
        if (!s[72]) begin
          m_mant <= s[71:8]; m_guard <= s[7:0]; m_exp <= e_in;
          m_ovf <= 0; m_inx <= 0;
        end else if (e1 == 15'h7FFF) begin
          m_mant <= '0; m_guard <= s[7:0]; m_exp <= 15'h7FFF;
          m_ovf <= 1; m_inx <= (s[71:8] != 0);
        end else begin
          m_mant  <= {1'b1, s[71:9]};
          m_guard <= {s[8], 6'd0, (s[7:0] != 0)};
          m_exp   <= e1;
          m_ovf <= 0; m_inx <= 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (mant !== m_mant || guard !== m_guard || exp_r !== m_exp ||
          ovf !== m_ovf || inx !== m_inx || done !== m_done) begin
        fails++;
        $display("FAIL %s: got mant=%h guard=%h exp=%h ovf=%b inx=%b done=%b exp mant=%h guard=%h exp=%h ovf=%b inx=%b done=%b",
                 m_tag, mant, guard, exp_r, ovf, inx, done,
                 m_mant, m_guard, m_exp, m_ovf, m_inx, m_done);
      end
    end
  end

  task automatic op(input logic [63:0] am, input logic [7:0] ag,
                    input logic [63:0] bm, input logic [7:0] bg,
                    input logic [14:0] e, input string tag);
    @(negedge clk);
    a_m = am; a_g = ag; b_m = bm; b_g = bg; e_in = e; cur_tag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_m = ~am; b_m = ~bm; e_in = ~e;  // disturb inputs while idle (R1 hold)
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);  // R9 reset state checked each cycle
    rst_n = 1'b1;
    op(64'h1234_5678_9ABC_DEF0, 8'h11, 64'h0000_0001_0000_0001, 8'h22, 15'h3FFF, "R2");
    op(64'h0000_0000_FFFF_FFFF, 8'h80, 64'h0, 8'h80, 15'h0100, "R3");
    op(64'hC000_0000_0000_0000, 8'h00, 64'hC000_0000_0000_0000, 8'h00, 15'h4000, "R4");
    op(64'h8000_0000_0000_0001, 8'h01, 64'h8000_0000_0000_0000, 8'h00, 15'h1234, "R5");
    op(64'h8000_0000_0000_0001, 8'h00, 64'h8000_0000_0000_0000, 8'h00, 15'h1234, "R5");
    op(64'hFFFF_FFFF_FFFF_FFFF, 8'h05, 64'h2, 8'h00, 15'h7FFE, "R6");
    op(64'h8000_0000_0000_0000, 8'h10, 64'h8000_0000_0000_0000, 8'h01, 15'h7FFE, "R7");
    op(64'hFFFF_0000_0000_0000, 8'h00, 64'h0001_0000_0000_0000, 8'h01, 15'h7FFE, "R7");
    op(64'h0000_0000_0000_0001, 8'h00, 64'h1, 8'h00, 15'h7FFE, "R8");
    for (int i = 0; i < 24; i++)
      op({$urandom, $urandom}, 8'($urandom), {$urandom, $urandom}, 8'($urandom),
         15'($urandom), "R4");
    // back-to-back starts
    @(negedge clk);
    a_m = 64'hF000_0000_0000_0000; b_m = 64'hF000_0000_0000_0000; a_g = 8'h3; b_g = 8'h0;
    e_in = 15'h0042; cur_tag = "R1"; start = 1'b1;
    @(negedge clk);
    a_m = 64'h1; b_m = 64'h2;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule